// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Watchdog Prescaler

This block is an 8-bit up-counter that advances either on an internal instruction tick (one in every four clocks) or on a chosen edge of an external count pin. An 8-bit ripple prescaler sits in front of it. A single assignment bit lends that prescaler either to the timer or to a watchdog path. The watchdog path counts a tick input from a separate slow oscillator and pulses a time-out output. Whichever path does not own the prescaler runs at ratio one.

Software reaches the block through a plain register port: a write strobe with an address and data, and a combinational read mux. There are three registers: the count, an option byte holding the clock-source, edge, assignment and ratio controls, and an interrupt-control byte. The interrupt-control byte carries the overflow flag and its enable. When the count wraps from FFh to 00h the flag is set, and the interrupt request follows the flag gated by the enable. A sleep input stops the timer path and leaves the watchdog path running. The port has no data stream, so it has no valid/ready pair and no back-pressure; every write strobe is accepted in the cycle it is presented.

Top module: `tmr0w_top`

## Requirements
- R1: After reset the count reads 00h, the option byte reads FFh, bits 7:1 of the interrupt-control byte read 0, and the interrupt request is low.
- R2: Address 0 selects the count, 1 the option byte, 2 the interrupt-control byte, and 3 reads 00h. Option bits 7:6 and interrupt-control bits 7:6, 4:3, 1 and 0 are stored as written and read back unchanged. Outside a write, the count changes only by one step.
- R3: Option bit 5 picks the count source: 0 is the instruction tick, one pulse every 4 clocks; 1 is the external pin, after a two-flop synchronizer.
- R4: Option bit 4 picks the pin edge: 0 counts rising edges, 1 counts falling edges.
- R5: With option bit 3 at 0 the prescaler belongs to the timer, and the count advances once every 2^(k+1) source events, where k is option bits 2:0.
- R6: With option bit 3 at 1 the timer advances on every source event, and the watchdog time-out pulses once every 2^k watchdog ticks. With bit 3 at 0 every watchdog tick gives a time-out one clock later.
- R7: A count write loads the value at once. It also clears the prescaler when the prescaler belongs to the timer, and drops all timer increments until two instruction ticks have passed.
- R8: An increment from FFh sets interrupt-control bit 2. The interrupt request equals bit 2 AND bit 5.
- R9: The flag stays set until a write to interrupt-control puts 0 in bit 2. An overflow in the same cycle as that write wins.
- R10: While sleep is high the count holds, and the watchdog time-out keeps pulsing.
- R11: A write that changes option bit 3 clears the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| t_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | One-clock pulse from the watchdog oscillator |
| sleep | input | 1 | Stops the timer path while high |
| irq | output | 1 | Timer interrupt request |
| wdt_timeout | output | 1 | One-clock watchdog time-out pulse |

## Verification
A prescaler left holding stale residue after an assignment change or a count write shows up only later, as one count step arriving too early. The bench therefore pairs such events with a short run of pin edges just below a ratio boundary and reads the count straight after. A broken hold-off counter moves the count within the first two instruction ticks, so a fixed 40-clock window after a write must show exactly eight steps. A flag that fails to latch or to clear shows at the interrupt pin in the next cycle. A watchdog ratio error shows as a wrong number of time-out pulses over a burst of sixteen ticks.

// File: rtl/tmr0w_pkg.sv
package tmr0w_pkg;
  localparam int DATA_W = 8;
  localparam int INTC_EN_BIT = 5;
  localparam int INTC_FLAG_BIT = 2;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_OPTION = 2'd1,
    SEL_INTCTL = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       src_pin;
    logic       fall_edge;
    logic       psc_to_wdt;
    logic [2:0] ratio;
  } option_t;
endpackage

// File: rtl/tmr0w_evt_src.sv
module tmr0w_evt_src #(
  parameter int CLK_PER_INSTR = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic src_pin,
  input  logic fall_edge,
  output logic instr_tick,
  output logic evt
);
  localparam int PH_W = (CLK_PER_INSTR > 1) ? $clog2(CLK_PER_INSTR) : 1;

  logic [PH_W-1:0]      ph_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 newer, older, pin_evt;

  // instruction-cycle tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (ph_q == PH_W'(CLK_PER_INSTR - 1)) ph_q <= '0;
    else ph_q <= ph_q + PH_W'(1);
  end
  assign instr_tick = (ph_q == PH_W'(CLK_PER_INSTR - 1));

  // pin synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-1:0], pin};
  end

  assign newer   = sync_q[SYNC_STAGES-1];
  assign older   = sync_q[SYNC_STAGES];
  assign pin_evt = fall_edge ? (older & ~newer) : (newer & ~older);
  assign evt     = src_pin ? pin_evt : instr_tick;
endmodule

// File: rtl/tmr0w_prescaler.sv
module tmr0w_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             to_wdt,
  input  logic [SEL_W-1:0] sel,
  input  logic             tmr_evt,
  input  logic             wdt_evt,
  output logic             tmr_inc,
  output logic             wdt_out
);
  localparam int PSC_W = 1 << SEL_W;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] run;
  logic [SEL_W-1:0] sel_m1;
  logic             src_evt, tap_tmr, tap_wdt, wdt_hit;

  // run[i] is high when psc_q[i:0] is all ones, i.e. the next event carries past bit i
  assign run[0] = psc_q[0];
  for (genvar i = 1; i < PSC_W; i++) begin : g_run
    assign run[i] = run[i-1] & psc_q[i];
  end

  assign sel_m1  = sel - SEL_W'(1);
  assign tap_tmr = run[sel];
  assign tap_wdt = (sel == '0) ? 1'b1 : run[sel_m1];
  assign src_evt = to_wdt ? wdt_evt : tmr_evt;

  assign tmr_inc = to_wdt ? tmr_evt : (tmr_evt & tap_tmr);
  assign wdt_hit = to_wdt ? (wdt_evt & tap_wdt) : wdt_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (src_evt) psc_q <= psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_out <= 1'b0;
    else wdt_out <= wdt_hit;
  end
endmodule

// File: rtl/tmr0w_counter.sv
module tmr0w_counter #(
  parameter int DW = 8,
  parameter int HOLD_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          inc,
  input  logic          instr_tick,
  input  logic          flag_wr,
  input  logic          flag_wr_val,
  output logic [DW-1:0] count,
  output logic          armed,
  output logic          flag
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q;
  logic          wrap;

  assign wrap  = inc && !load && (count == '1);
  assign armed = (hold_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (load) count <= load_val;
    else if (inc) count <= count + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (load) hold_q <= HW'(HOLD_TICKS);
    else if (instr_tick && hold_q != '0) hold_q <= hold_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (flag_wr) flag <= flag_wr_val;
  end
endmodule

// File: rtl/tmr0w_top.sv
module tmr0w_top
  import tmr0w_pkg::*;
#(
  parameter int CLK_PER_INSTR = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int SEL_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              t_pin,
  input  logic              wdt_tick,
  input  logic              sleep,
  output logic              irq,
  output logic              wdt_timeout
);
  option_t           opt_q;
  logic [7:3]        intc_hi_q;
  logic              intc_b1_q, intc_b0_q;
  logic              wr_count, wr_option, wr_intctl;
  logic              instr_tick, src_evt, tmr_evt_g, tmr_inc, psc_clr;
  logic              armed, flag_q;
  logic [DATA_W-1:0] cnt_q, intc_rd;
  option_t           opt_new;

  assign wr_count  = wr_en && (reg_sel_e'(wr_addr) == SEL_COUNT);
  assign wr_option = wr_en && (reg_sel_e'(wr_addr) == SEL_OPTION);
  assign wr_intctl = wr_en && (reg_sel_e'(wr_addr) == SEL_INTCTL);
  assign opt_new   = option_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= option_t'('1);
    else if (wr_option) opt_q <= opt_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intc_hi_q <= '0;
      intc_b1_q <= 1'b0;
    end else if (wr_intctl) begin
      intc_hi_q <= wr_data[7:3];
      intc_b1_q <= wr_data[1];
    end
  end

  // bit 0 belongs to a neighbouring change detector and keeps its value through reset
  always_ff @(posedge clk) begin
    if (wr_intctl) intc_b0_q <= wr_data[0];
  end

  assign psc_clr = (wr_count && !opt_q.psc_to_wdt) ||
                   (wr_option && (opt_new.psc_to_wdt != opt_q.psc_to_wdt));

  tmr0w_evt_src #(
    .CLK_PER_INSTR(CLK_PER_INSTR),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (t_pin),
    .src_pin   (opt_q.src_pin),
    .fall_edge (opt_q.fall_edge),
    .instr_tick(instr_tick),
    .evt       (src_evt)
  );

  assign tmr_evt_g = src_evt && armed && !sleep;

  tmr0w_prescaler #(
    .SEL_W(SEL_W)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (psc_clr),
    .to_wdt (opt_q.psc_to_wdt),
    .sel    (opt_q.ratio[SEL_W-1:0]),
    .tmr_evt(tmr_evt_g),
    .wdt_evt(wdt_tick),
    .tmr_inc(tmr_inc),
    .wdt_out(wdt_timeout)
  );

  tmr0w_counter #(
    .DW        (DATA_W),
    .HOLD_TICKS(2)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_count),
    .load_val   (wr_data),
    .inc        (tmr_inc),
    .instr_tick (instr_tick),
    .flag_wr    (wr_intctl),
    .flag_wr_val(wr_data[INTC_FLAG_BIT]),
    .count      (cnt_q),
    .armed      (armed),
    .flag       (flag_q)
  );

  assign intc_rd = {intc_hi_q, flag_q, intc_b1_q, intc_b0_q};
  assign irq     = flag_q & intc_hi_q[INTC_EN_BIT];

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_COUNT:  rd_data = cnt_q;
      SEL_OPTION: rd_data = opt_q;
      SEL_INTCTL: rd_data = intc_rd;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr0w_chk.sv
module tmr0w_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       wdt_tick,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] count,
  input logic       flag,
  input logic       inc,
  input logic       to_wdt,
  input logic       wdt_timeout
);
  logic wr_cnt, wr_ic;
  assign wr_cnt = wr_en && (wr_addr == 2'd0);
  assign wr_ic  = wr_en && (wr_addr == 2'd2);

  // R7: a count write lands in the next cycle
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(wr_data));

  // R2: outside writes the count only steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (count == $past(count) || count == $past(count) + 8'd1));

  // R10: sleep freezes the count
  a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_cnt) |=> $stable(count));

  // R8: an increment from all ones raises the flag
  a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count == 8'hFF && !wr_cnt) |=> flag);

  // R9: the flag is sticky without a control write
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_ic) |=> flag);

  // R6: an unscaled watchdog passes every tick through
  a_r6_wdt_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_wdt && wdt_tick) |=> wdt_timeout);
endmodule

bind tmr0w_top tmr0w_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep      (sleep),
  .wdt_tick   (wdt_tick),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .count      (cnt_q),
  .flag       (flag_q),
  .inc        (tmr_inc),
  .to_wdt     (opt_q.psc_to_wdt),
  .wdt_timeout(wdt_timeout)
);

// File: tb/tmr0w_top_tb.sv
`timescale 1ns/1ps
module tmr0w_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       t_pin = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       sleep = 1'b0;
  logic       irq, wdt_timeout;

  int n_tests = 0;
  int n_fail = 0;
  int to_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr0w_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .t_pin(t_pin), .wdt_tick(wdt_tick),
    .sleep(sleep), .irq(irq), .wdt_timeout(wdt_timeout)
  );

  always @(posedge clk) if (wdt_timeout) to_cnt <= to_cnt + 1;

  // {src_pin, fall_edge, ratio[2:0], to_wdt, pulses[7:0], expected[7:0]}
  localparam logic [21:0] VEC [0:5] = '{
    {1'b1, 1'b0, 3'd0, 1'b0, 8'd7,  8'd3},
    {1'b1, 1'b0, 3'd1, 1'b0, 8'd9,  8'd2},
    {1'b1, 1'b0, 3'd2, 1'b0, 8'd16, 8'd2},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'd5,  8'd5},
    {1'b1, 1'b1, 3'd0, 1'b0, 8'd6,  8'd3},
    {1'b1, 1'b1, 3'd0, 1'b1, 8'd4,  8'd4}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_pin(input logic idle, input int n);
    for (int i = 0; i < n; i++) begin
      t_pin = ~idle; repeat (4) @(negedge clk);
      t_pin = idle;  repeat (4) @(negedge clk);
    end
  endtask

  task automatic tick_wdt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_tick = 1'b1;
      @(negedge clk); wdt_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 count", d, 8'h00);
    rd(2'd1, d); check("R1 option", d, 8'hFF);
    rd(2'd2, d); check("R1 intctl", d & 8'hFE, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 storage of bits owned by neighbours, unused address
    wr(2'd1, 8'hC8); rd(2'd1, d); check("R2 option readback", d, 8'hC8);
    wr(2'd2, 8'h8B); rd(2'd2, d); check("R2 intctl readback", d, 8'h8B);
    check("R2 irq stays low", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R2 unused address", d, 8'h00);

    // R3 R4 R5 R6: pin counting under several ratios and edges
    for (int v = 0; v < 6; v++) begin
      logic idle;
      idle = VEC[v][20];
      t_pin = idle;
      repeat (6) @(negedge clk);
      wr(2'd1, {2'b00, VEC[v][21], VEC[v][20], VEC[v][16], VEC[v][19:17]});
      wr(2'd0, 8'h00);
      repeat (12) @(negedge clk);
      pulse_pin(idle, int'(VEC[v][15:8]));
      repeat (8) @(negedge clk);
      rd(2'd0, d);
      check($sformatf("R3 R4 R5 R6 vector %0d", v), d, VEC[v][7:0]);
    end

    // R11: changing the assignment bit drops prescaler residue
    t_pin = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd1, 8'h22);
    wr(2'd0, 8'h00);
    repeat (12) @(negedge clk);
    pulse_pin(1'b0, 5);
    repeat (8) @(negedge clk);
    rd(2'd0, d); check("R5 below ratio 8", d, 8'h00);
    wr(2'd1, 8'h2A);
    wr(2'd1, 8'h22);
    pulse_pin(1'b0, 4);
    repeat (8) @(negedge clk);
    rd(2'd0, d); check("R11 residue cleared", d, 8'h00);
    pulse_pin(1'b0, 4);
    repeat (8) @(negedge clk);
    rd(2'd0, d); check("R11 full ratio after clear", d, 8'h01);

    // R6 watchdog ratios
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h0A);
    base = to_cnt;
    tick_wdt(16);
    repeat (4) @(negedge clk);
    check("R6 watchdog ratio 4", 8'(to_cnt - base), 8'd4);
    wr(2'd1, 8'h02);
    base = to_cnt;
    tick_wdt(5);
    repeat (4) @(negedge clk);
    check("R6 watchdog unscaled", 8'(to_cnt - base), 8'd5);

    // R7 write hold-off: 40 clocks hold 10 ticks, 2 are dropped
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h10);
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd(2'd0, d); check("R7 hold-off after write", d, 8'h18);

    // R10 sleep freezes timer, watchdog runs
    sleep = 1'b1;
    wr(2'd0, 8'h50);
    base = to_cnt;
    tick_wdt(3);
    repeat (28) @(negedge clk);
    rd(2'd0, d); check("R10 count frozen", d, 8'h50);
    check("R10 watchdog in sleep", 8'(to_cnt - base), 8'd3);
    sleep = 1'b0;

    // R8 R9 overflow flag and interrupt gating
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd(2'd0, d); check("R8 wrapped count", d, 8'h06);
    rd(2'd2, d); check("R8 flag set", d & 8'h04, 8'h04);
    check("R8 irq masked", {7'd0, irq}, 8'h00);
    repeat (20) @(negedge clk);
    rd(2'd2, d); check("R9 flag sticky", d & 8'h04, 8'h04);
    wr(2'd2, 8'h24);
    check("R8 irq enabled", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h20);
    rd(2'd2, d); check("R9 flag cleared", d & 8'hFE, 8'h20);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule